// File: doc/BRIEF.md
# Low-Voltage Reset Filter and Stretcher

This block turns a digital undervoltage flag from an external core-supply comparator into a clean core reset. The comparator reports the core regulator output, nominally 1.8 V, falling below a threshold near 1.5 V. The flag is first synchronized into the system clock domain. It must then stay active without a break for a fixed number of clocks before the reset asserts, so short supply dips are ignored. Once the supply is back above threshold, the reset is held for a long fixed time before it is released.

A small power-control register sits beside the filter. One bit decides whether the monitor stays active during power-down. Another bit enables the watchdog while the chip is idle. The register returns to its initial value on a hardware reset, a USB bus reset or a resume reset. The comparator, the voltage reference and the watchdog itself are outside this block.

Top module: `lvr_reset_top`

## Requirements
- R1: The flag passes through a two-stage synchronizer. With `pd_mode`=0, a flag that is high for N consecutive clock edges with N >= 512 sets `core_rst` 515 edges after the first high edge. A flag that is high for 511 edges or fewer never sets `core_rst`.
- R2: After the synchronized flag falls, `core_rst` stays high for 65536 more clocks. For a single dip of N >= 512 edges, `core_rst` is therefore sampled high for (N - 512) + 65536 cycles.
- R3: If undervoltage is confirmed again while the hold is running, `core_rst` stays high without a gap and the 65536-clock hold starts over from the last recovery.
- R4: While `pd_mode`=1 and control bit 0 is 0, the flag is ignored and `core_rst` stays low.
- R5: While `pd_mode`=1 and control bit 0 is 1, the flag is monitored exactly as in R1. While `pd_mode`=0, the flag is monitored whatever the value of bit 0.
- R6: Control bit 0 (monitor-in-power-down) resets to 1. Control bit 2 (watchdog-in-idle) resets to 0. Both are written through `ctl_wr_en`/`ctl_wdata` and read on `ctl_rdata`.
- R7: Control bits 7..3 and bit 1 always read as 0, whatever was written to them.
- R8: `hw_rst_n` low, a one-cycle `usb_bus_rst` or a one-cycle `resume_rst` returns `ctl_rdata` to 8'h01.
- R9: `wdt_idle_en` equals control bit 2 AND `idle_mode`.
- R10: While `hw_rst_n` is low, `core_rst` is 0 and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| usb_bus_rst | input | 1 | Synchronous clear of the control register (USB reset) |
| resume_rst | input | 1 | Synchronous clear of the control register (resume) |
| uv_flag_async | input | 1 | Undervoltage flag from the comparator, asynchronous |
| pd_mode | input | 1 | Chip is in power-down |
| idle_mode | input | 1 | Chip is in idle |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Write data for the control register |
| ctl_rdata | output | 8 | Control register read value |
| core_rst | output | 1 | Filtered and stretched core reset, active high |
| wdt_idle_en | output | 1 | Watchdog enable for idle mode |

## Verification
The assertions assume that `pd_mode`, `idle_mode`, the register strobes and the two synchronous clears come from logic on the same clock. Only `uv_flag_async` may change at any time. The stimulus drives every input on the falling edge, and mode inputs change only between flag pulses, so no mode change coincides with a rising edge. Dips during the hold window are kept shorter than 65536 clocks and longer than the filter window, so each re-confirmation restarts the hold in a way the bench can predict.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
   localparam int CTL_W       = 8;
   localparam int PD_MON_BIT  = 0;
   localparam int WDT_IDL_BIT = 2;
   localparam logic [CTL_W-1:0] CTL_INIT  = 8'h01;
   localparam logic [CTL_W-1:0] CTL_WMASK = (CTL_W'(1) << PD_MON_BIT) | (CTL_W'(1) << WDT_IDL_BIT);
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lvr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[i] <= 1'b0;
         else if (i == 0)
            chain[i] <= d_async;
         else
            chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lvr_persist.sv
module lvr_persist #(
   parameter int LOG2_LEN = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_in,
   output logic uv_conf
);
   if (LOG2_LEN < 1) begin : g_bad_len
      $error("lvr_persist: LOG2_LEN must be at least 1");
   end

   localparam int CW = LOG2_LEN;
   localparam logic [CW-1:0] LAST = {CW{1'b1}};

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         uv_conf <= 1'b0;
      end else if (!flag_in) begin
         run_cnt <= '0;
         uv_conf <= 1'b0;
      end else if (run_cnt == LAST) begin
         uv_conf <= 1'b1;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // R1
   flag_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_in |=> !uv_conf);
   // R1
   conf_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_conf) |-> $past(flag_in));
endmodule

// File: rtl/lvr_hold.sv
module lvr_hold #(
   parameter int LOG2_HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_conf,
   output logic rst_out
);
   if (LOG2_HOLD < 1) begin : g_bad_hold
      $error("lvr_hold: LOG2_HOLD must be at least 1");
   end

   localparam int HW = LOG2_HOLD;
   localparam logic [HW-1:0] LAST = {HW{1'b1}};

   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         rst_out  <= 1'b0;
      end else if (uv_conf) begin
         hold_cnt <= '0;
         rst_out  <= 1'b1;
      end else if (rst_out) begin
         if (hold_cnt == LAST) begin
            hold_cnt <= '0;
            rst_out  <= 1'b0;
         end else begin
            hold_cnt <= hold_cnt + 1'b1;
         end
      end
   end

   // R2
   conf_sets_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_conf |=> rst_out);
   // R2
   no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_out && !uv_conf) |=> !rst_out);
   // R3
   release_after_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> $past(!uv_conf));
endmodule

// File: rtl/lvr_ctl_reg.sv
module lvr_ctl_reg
   import lvr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] rdata,
   output logic             pd_mon_en,
   output logic             wdt_bit
);
   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= CTL_INIT;
      else if (soft_clr)
         ctl_q <= CTL_INIT;
      else if (wr_en)
         ctl_q <= wdata & CTL_WMASK;
   end

   assign rdata     = ctl_q;
   assign pd_mon_en = ctl_q[PD_MON_BIT];
   assign wdt_bit   = ctl_q[WDT_IDL_BIT];

   // R7
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~CTL_WMASK) == '0);
   // R8
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> rdata == CTL_INIT);
endmodule

// File: rtl/lvr_reset_top.sv
module lvr_reset_top
   import lvr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LOG2   = 9,
   parameter int HOLD_LOG2   = 16
) (
   input  logic             clk,
   input  logic             hw_rst_n,
   input  logic             usb_bus_rst,
   input  logic             resume_rst,
   input  logic             uv_flag_async,
   input  logic             pd_mode,
   input  logic             idle_mode,
   input  logic             ctl_wr_en,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             core_rst,
   output logic             wdt_idle_en
);
   logic uv_sync, uv_eff, uv_conf, pd_mon_en, wdt_bit;

   lvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(hw_rst_n), .d_async(uv_flag_async), .q_sync(uv_sync));

   lvr_ctl_reg u_ctl (
      .clk(clk), .rst_n(hw_rst_n), .soft_clr(usb_bus_rst | resume_rst),
      .wr_en(ctl_wr_en), .wdata(ctl_wdata), .rdata(ctl_rdata),
      .pd_mon_en(pd_mon_en), .wdt_bit(wdt_bit));

   assign uv_eff = uv_sync & (~pd_mode | pd_mon_en);

   lvr_persist #(.LOG2_LEN(FILT_LOG2)) u_persist (
      .clk(clk), .rst_n(hw_rst_n), .flag_in(uv_eff), .uv_conf(uv_conf));

   lvr_hold #(.LOG2_HOLD(HOLD_LOG2)) u_hold (
      .clk(clk), .rst_n(hw_rst_n), .uv_conf(uv_conf), .rst_out(core_rst));

   assign wdt_idle_en = wdt_bit & idle_mode;

   // R4
   pd_gate_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (pd_mode && !ctl_rdata[PD_MON_BIT]) |=> !uv_conf);
   // R9
   wdt_idle_only_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !idle_mode |-> !wdt_idle_en);
endmodule

// File: tb/tb_lvr_reset_top.sv
module tb_lvr_reset_top;
   logic       clk = 1'b0;
   logic       hw_rst_n = 1'b0;
   logic       usb_bus_rst = 1'b0, resume_rst = 1'b0;
   logic       uv_flag_async = 1'b0, pd_mode = 1'b0, idle_mode = 1'b0;
   logic       ctl_wr_en = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       core_rst, wdt_idle_en;

   int total = 0, bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   lvr_reset_top dut (
      .clk(clk), .hw_rst_n(hw_rst_n), .usb_bus_rst(usb_bus_rst), .resume_rst(resume_rst),
      .uv_flag_async(uv_flag_async), .pd_mode(pd_mode), .idle_mode(idle_mode),
      .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .core_rst(core_rst), .wdt_idle_en(wdt_idle_en));

   typedef struct packed {
      logic        pd;
      logic        idle;
      logic [7:0]  wdat;
      logic [15:0] len;
      logic        exp_rst;
      logic [7:0]  exp_rd;
      logic        exp_wdt;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 8'h01, 16'd300, 1'b0, 8'h01, 1'b0},
      '{1'b0, 1'b1, 8'h04, 16'd511, 1'b0, 8'h04, 1'b1},
      '{1'b0, 1'b0, 8'h00, 16'd512, 1'b1, 8'h00, 1'b0},
      '{1'b1, 1'b0, 8'h00, 16'd900, 1'b0, 8'h00, 1'b0},
      '{1'b1, 1'b0, 8'h01, 16'd512, 1'b1, 8'h01, 1'b0},
      '{1'b0, 1'b1, 8'hFF, 16'd0,   1'b0, 8'h05, 1'b1},
      '{1'b1, 1'b1, 8'hFA, 16'd700, 1'b0, 8'h00, 1'b0},
      '{1'b1, 1'b0, 8'h05, 16'd600, 1'b1, 8'h05, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_hw_reset();
      @(negedge clk) hw_rst_n = 1'b0;
      uv_flag_async = 1'b0;
      repeat (3) @(negedge clk);
      hw_rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk) ctl_wr_en = 1'b1; ctl_wdata = v;
      @(negedge clk) ctl_wr_en = 1'b0;
   endtask

   task automatic pulse_flag(input int len);
      if (len > 0) begin
         @(negedge clk) uv_flag_async = 1'b1;
         repeat (len) @(negedge clk);
         uv_flag_async = 1'b0;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hi_cnt;
      repeat (3) @(negedge clk);
      // R10 and R6: reset state
      chk("R10 core_rst during reset", core_rst, 0);
      hw_rst_n = 1'b1;
      idle_mode = 1'b1;
      @(negedge clk);
      chk("R6 rdata init", ctl_rdata, 8'h01);
      chk("R9 wdt off at init", wdt_idle_en, 0);

      // Vector table: R1 R4 R5 R6 R7 R9
      foreach (VECS[i]) begin
         pd_mode = VECS[i].pd;
         idle_mode = VECS[i].idle;
         wr(VECS[i].wdat);
         pulse_flag(int'(VECS[i].len));
         repeat (20) @(negedge clk);
         chk($sformatf("R1/R4/R5 vec%0d core_rst", i), core_rst, int'(VECS[i].exp_rst));
         chk($sformatf("R6/R7 vec%0d rdata", i), ctl_rdata, int'(VECS[i].exp_rd));
         chk($sformatf("R9 vec%0d wdt", i), wdt_idle_en, int'(VECS[i].exp_wdt));
         do_hw_reset();
         @(negedge clk);
         chk($sformatf("R10 vec%0d rst cleared", i), core_rst, 0);
      end
      pd_mode = 1'b0;

      // R1: exact assertion edge
      @(negedge clk) uv_flag_async = 1'b1;
      repeat (514) @(negedge clk);
      chk("R1 still low after 514 edges", core_rst, 0);
      @(negedge clk);
      chk("R1 high after 515 edges", core_rst, 1);
      uv_flag_async = 1'b0;
      do_hw_reset();

      // R8: soft clears
      wr(8'h04);
      @(negedge clk) usb_bus_rst = 1'b1;
      @(negedge clk) usb_bus_rst = 1'b0;
      chk("R8 usb clear", ctl_rdata, 8'h01);
      wr(8'h04);
      @(negedge clk) resume_rst = 1'b1;
      @(negedge clk) resume_rst = 1'b0;
      chk("R8 resume clear", ctl_rdata, 8'h01);
      wr(8'h04);
      do_hw_reset();
      chk("R8 hw clear", ctl_rdata, 8'h01);

      // R2 R3: 600 high, 1000 low, 600 high, then hold
      hi_cnt = 0;
      @(negedge clk);
      for (int k = 0; k < 70000; k++) begin
         if (core_rst) hi_cnt++;
         uv_flag_async = (k < 600) || (k >= 1600 && k < 2200);
         @(negedge clk);
      end
      chk("R2/R3 total reset length", hi_cnt, 2200 + 65024);
      chk("R2 released at end", core_rst, 0);

      // R2: single dip of 512 gives exactly 65536
      hi_cnt = 0;
      for (int k = 0; k < 66200; k++) begin
         if (core_rst) hi_cnt++;
         uv_flag_async = (k < 512);
         @(negedge clk);
      end
      chk("R2 single dip length", hi_cnt, 65536);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule